// File: doc/BRIEF.md
# Iterative Floating-Point Divide Core

This block divides two floating-point operands that arrive already unpacked. Each operand has a two-bit class code, a signaling flag for NaNs, a sign, a two's-complement exponent and a normalized mantissa. The mantissa holds `MANT_W` bits, including the integer bit and the guard and round bits, and its value is `mant / 2^(MANT_W-1)`, which lies in [1,2). A single `start` pulse launches an operation. Operand pairs that involve a zero, an infinity or a NaN are resolved from a fixed decision table in one cycle. Two finite nonzero operands go through a bit-serial restoring division. A trial subtraction decides the single normalization shift before the loop starts. After that, each cycle shifts the remainder, subtracts the divisor and keeps the difference when its sign is clear. This yields one quotient bit per cycle, most significant first.

The result comes back in the same unpacked form, together with a sticky bit taken from the final remainder and two exception flags: invalid operation and divide by zero. Rounding and repacking are left to the stage that follows.

Top module: `fdiv_core`

## Requirements
- R1: For two normal operands (class code 2'b01) with mantissas X and Y, the result mantissa is floor(X·2^(MANT_W-1)/Y) when X ≥ Y and floor(X·2^MANT_W/Y) when X < Y. Its top bit is therefore always 1. The result class is normal.
- R2: For two normal operands, the result exponent is ea − eb when X ≥ Y and ea − eb − 1 when X < Y, computed modulo 2^EXP_W.
- R3: For two normal operands, `res_sticky` is 1 exactly when the division leaves a nonzero remainder. It is 0 for every special-case result.
- R4: For two normal operands, the result sign is the XOR of the operand signs, and both flags are 0.
- R5: If either operand has class 2'b11 (NaN), the result is a NaN operand returned unchanged, including its signaling bit, sign, exponent and mantissa. The dividend is returned when it is the only NaN, or when it alone is signaling. Otherwise the divisor is returned. No flag is raised.
- R6: Inf/Inf and 0/0 return a quiet NaN (class 2'b11, signaling 0) with sign 0, exponent 0 and a mantissa with only bit MANT_W-2 set, and raise `flag_nv`.
- R7: A dividend of class zero (2'b00) or infinity (2'b10) divided by a non-NaN divisor of a different class is returned unchanged, keeping its own sign, with both flags 0.
- R8: A normal dividend divided by infinity gives class zero. A normal dividend divided by zero gives class infinity and raises `flag_dz`. In both cases the sign is the XOR of the operand signs, and the exponent and mantissa are the dividend's.
- R9: A special-case result shows `done` one cycle after the `start` cycle. A normal divide shows `done` MANT_W cycles after start when X ≥ Y and MANT_W+1 cycles after start when X < Y. `busy` is high in between, `done` is a single-cycle pulse, and the two are never high together.
- R10: `start` is ignored while `busy` is high.
- R11: After reset, `busy`, `done`, both flags and all result fields are 0.
- R12: Result outputs change only in a cycle in which `done` is high, and they hold their value until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an operation on the present operands |
| a_cls | input | 2 | Dividend class code |
| a_snan | input | 1 | Dividend signaling-NaN flag |
| a_sign | input | 1 | Dividend sign |
| a_exp | input | EXP_W | Dividend exponent |
| a_mant | input | MANT_W | Dividend mantissa |
| b_cls | input | 2 | Divisor class code |
| b_snan | input | 1 | Divisor signaling-NaN flag |
| b_sign | input | 1 | Divisor sign |
| b_exp | input | EXP_W | Divisor exponent |
| b_mant | input | MANT_W | Divisor mantissa |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle result-valid pulse |
| res_cls | output | 2 | Result class code |
| res_snan | output | 1 | Result signaling flag |
| res_sign | output | 1 | Result sign |
| res_exp | output | EXP_W | Result exponent |
| res_mant | output | MANT_W | Result mantissa |
| res_sticky | output | 1 | OR of the final remainder |
| flag_nv | output | 1 | Invalid-operation flag |
| flag_dz | output | 1 | Divide-by-zero flag |

## Verification
The bench checks several mantissa pairs on both sides of X = Y, including equal mantissas and near-extreme ratios.
- A wrong shift prediction shows up as a quotient off by a factor of two, an exponent off by one, or a latency off by one.
- A remainder that is too narrow, or a sign test on the wrong bit, corrupts the low quotient bits and the sticky bit.

The NaN-ordering cases cover mixes of signaling and quiet NaNs in both positions, so a design that always forwards one side returns the wrong payload. The dividend-passthrough cases use a negative dividend against a positive divisor, which exposes a sign XOR applied too early. A start pulse driven in the middle of an iteration catches a core that reloads or finishes early.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'b00,
    CLS_NORM = 2'b01,
    CLS_INF  = 2'b10,
    CLS_NAN  = 2'b11
  } fcls_e;

  // Outcome of the special-operand decision table
  typedef enum logic [2:0] {
    SP_NONE,    // both finite and nonzero: iterate
    SP_PASS_A,  // return dividend as-is
    SP_PASS_B,  // return divisor as-is
    SP_NEWNAN,  // fresh quiet NaN, invalid flag
    SP_ZERO,    // signed zero
    SP_INF      // signed infinity, divide-by-zero flag
  } sp_kind_e;

endpackage

// File: rtl/fdiv_special.sv
module fdiv_special
  import fdiv_pkg::*;
(
  input  logic [1:0] a_cls,
  input  logic       a_snan,
  input  logic [1:0] b_cls,
  input  logic       b_snan,
  output sp_kind_e   kind
);

  logic a_nan, b_nan, a_edge;

  assign a_nan  = (a_cls == CLS_NAN);
  assign b_nan  = (b_cls == CLS_NAN);
  assign a_edge = (a_cls == CLS_INF) || (a_cls == CLS_ZERO);

  always_comb begin
    if (a_nan || b_nan) begin
      // the dividend wins if it is the only NaN or the only signaling one
      kind = (a_nan && (!b_nan || (a_snan && !b_snan))) ? SP_PASS_A : SP_PASS_B;
    end else if (a_edge) begin
      kind = (a_cls == b_cls) ? SP_NEWNAN : SP_PASS_A;
    end else if (b_cls == CLS_INF) begin
      kind = SP_ZERO;
    end else if (b_cls == CLS_ZERO) begin
      kind = SP_INF;
    end else begin
      kind = SP_NONE;
    end
  end

endmodule

// File: rtl/fdiv_step.sv
module fdiv_step #(
  parameter int MANT_W = 12
) (
  input  logic [MANT_W:0]   rem_in,
  input  logic [MANT_W-1:0] divisor,
  output logic              ge,
  output logic [MANT_W:0]   rem_out
);

  localparam int DW = MANT_W + 2;

  logic [DW-1:0] diff;

  // compare by the borrow of a full-width subtraction
  assign diff    = {1'b0, rem_in} - {2'b00, divisor};
  assign ge      = ~diff[DW-1];
  assign rem_out = ge ? diff[MANT_W:0] : rem_in;

endmodule

// File: rtl/fdiv_core.sv
module fdiv_core
  import fdiv_pkg::*;
#(
  parameter int MANT_W = 12,
  parameter int EXP_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        a_cls,
  input  logic              a_snan,
  input  logic              a_sign,
  input  logic [EXP_W-1:0]  a_exp,
  input  logic [MANT_W-1:0] a_mant,
  input  logic [1:0]        b_cls,
  input  logic              b_snan,
  input  logic              b_sign,
  input  logic [EXP_W-1:0]  b_exp,
  input  logic [MANT_W-1:0] b_mant,
  output logic              busy,
  output logic              done,
  output logic [1:0]        res_cls,
  output logic              res_snan,
  output logic              res_sign,
  output logic [EXP_W-1:0]  res_exp,
  output logic [MANT_W-1:0] res_mant,
  output logic              res_sticky,
  output logic              flag_nv,
  output logic              flag_dz
);

  localparam int CNT_W = $clog2(MANT_W + 1);
  localparam logic [MANT_W-1:0] QNAN_MANT = MANT_W'(1) << (MANT_W - 2);

  sp_kind_e          kind;
  logic [MANT_W:0]   rem_q;
  logic [MANT_W-1:0] quo_q;
  logic [MANT_W-1:0] div_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [EXP_W-1:0]  exp_q;
  logic              sign_q;

  logic [MANT_W:0]   step_in, step_rem;
  logic [MANT_W-1:0] step_div;
  logic              step_ge;

  logic [1:0]        sp_cls;
  logic              sp_snan, sp_sign, sp_nv, sp_dz;
  logic [EXP_W-1:0]  sp_exp;
  logic [MANT_W-1:0] sp_mant;

  fdiv_special u_spec (
    .a_cls  (a_cls),
    .a_snan (a_snan),
    .b_cls  (b_cls),
    .b_snan (b_snan),
    .kind   (kind)
  );

  // one subtractor shared by the trial step and every loop step
  assign step_in  = busy ? {rem_q[MANT_W-1:0], 1'b0} : {1'b0, a_mant};
  assign step_div = busy ? div_q : b_mant;

  fdiv_step #(.MANT_W(MANT_W)) u_step (
    .rem_in  (step_in),
    .divisor (step_div),
    .ge      (step_ge),
    .rem_out (step_rem)
  );

  always_comb begin
    sp_cls  = a_cls;
    sp_snan = a_snan;
    sp_sign = a_sign;
    sp_exp  = a_exp;
    sp_mant = a_mant;
    sp_nv   = 1'b0;
    sp_dz   = 1'b0;
    case (kind)
      SP_PASS_B: begin
        sp_cls  = b_cls;
        sp_snan = b_snan;
        sp_sign = b_sign;
        sp_exp  = b_exp;
        sp_mant = b_mant;
      end
      SP_NEWNAN: begin
        sp_cls  = CLS_NAN;
        sp_snan = 1'b0;
        sp_sign = 1'b0;
        sp_exp  = '0;
        sp_mant = QNAN_MANT;
        sp_nv   = 1'b1;
      end
      SP_ZERO: begin
        sp_cls  = CLS_ZERO;
        sp_sign = a_sign ^ b_sign;
      end
      SP_INF: begin
        sp_cls  = CLS_INF;
        sp_sign = a_sign ^ b_sign;
        sp_dz   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      rem_q      <= '0;
      quo_q      <= '0;
      div_q      <= '0;
      cnt_q      <= '0;
      exp_q      <= '0;
      sign_q     <= 1'b0;
      res_cls    <= '0;
      res_snan   <= 1'b0;
      res_sign   <= 1'b0;
      res_exp    <= '0;
      res_mant   <= '0;
      res_sticky <= 1'b0;
      flag_nv    <= 1'b0;
      flag_dz    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        rem_q <= step_rem;
        quo_q <= {quo_q[MANT_W-2:0], step_ge};
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy       <= 1'b0;
          done       <= 1'b1;
          res_cls    <= CLS_NORM;
          res_snan   <= 1'b0;
          res_sign   <= sign_q;
          res_exp    <= exp_q;
          res_mant   <= {quo_q[MANT_W-2:0], step_ge};
          res_sticky <= |step_rem;
          flag_nv    <= 1'b0;
          flag_dz    <= 1'b0;
        end
      end else if (start) begin
        if (kind == SP_NONE) begin
          // trial step fixes the normalization shift up front
          busy   <= 1'b1;
          div_q  <= b_mant;
          rem_q  <= step_rem;
          quo_q  <= {{(MANT_W-1){1'b0}}, step_ge};
          cnt_q  <= step_ge ? CNT_W'(MANT_W - 1) : CNT_W'(MANT_W);
          exp_q  <= a_exp - b_exp - {{(EXP_W-1){1'b0}}, ~step_ge};
          sign_q <= a_sign ^ b_sign;
        end else begin
          done       <= 1'b1;
          res_cls    <= sp_cls;
          res_snan   <= sp_snan;
          res_sign   <= sp_sign;
          res_exp    <= sp_exp;
          res_mant   <= sp_mant;
          res_sticky <= 1'b0;
          flag_nv    <= sp_nv;
          flag_dz    <= sp_dz;
        end
      end
    end
  end

endmodule

// File: rtl/fdiv_core_chk.sv
module fdiv_core_chk #(
  parameter int MANT_W = 12,
  parameter int EXP_W  = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic [1:0]        res_cls,
  input logic              res_snan,
  input logic              res_sign,
  input logic [EXP_W-1:0]  res_exp,
  input logic [MANT_W-1:0] res_mant,
  input logic              flag_nv,
  input logic              flag_dz,
  input logic [MANT_W-1:0] div_q
);

  p_busy_done_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  p_busy_ends_in_done_r9: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));

  p_norm_msb_r1: assert property (@(posedge clk) disable iff (rst)
    (done && res_cls == 2'b01) |-> res_mant[MANT_W-1]);

  p_norm_no_flags_r4: assert property (@(posedge clk) disable iff (rst)
    (done && res_cls == 2'b01) |-> (!flag_nv && !flag_dz));

  p_nv_quiet_nan_r6: assert property (@(posedge clk) disable iff (rst)
    (done && flag_nv) |-> (res_cls == 2'b11 && !res_snan && !res_sign && !flag_dz));

  p_dz_gives_inf_r8: assert property (@(posedge clk) disable iff (rst)
    (done && flag_dz) |-> (res_cls == 2'b10));

  p_divisor_held_r10: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(div_q));

  p_result_hold_r12: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(res_mant) && $stable(res_exp) && $stable(res_cls)));

endmodule

bind fdiv_core fdiv_core_chk #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .res_cls  (res_cls),
  .res_snan (res_snan),
  .res_sign (res_sign),
  .res_exp  (res_exp),
  .res_mant (res_mant),
  .flag_nv  (flag_nv),
  .flag_dz  (flag_dz),
  .div_q    (div_q)
);

// File: tb/fdiv_core_tb_top.sv
module fdiv_core_tb_top;

  localparam int MW = 12;
  localparam int EW = 10;
  localparam int NV = 19;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] a_cls = '0, b_cls = '0;
  logic a_snan = 1'b0, a_sign = 1'b0, b_snan = 1'b0, b_sign = 1'b0;
  logic [EW-1:0] a_exp = '0, b_exp = '0;
  logic [MW-1:0] a_mant = '0, b_mant = '0;
  logic busy, done, res_snan, res_sign, res_sticky, flag_nv, flag_dz;
  logic [1:0] res_cls;
  logic [EW-1:0] res_exp;
  logic [MW-1:0] res_mant;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  fdiv_core #(.MANT_W(MW), .EXP_W(EW)) dut_i (
    .clk(clk), .rst(rst), .start(start),
    .a_cls(a_cls), .a_snan(a_snan), .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
    .b_cls(b_cls), .b_snan(b_snan), .b_sign(b_sign), .b_exp(b_exp), .b_mant(b_mant),
    .busy(busy), .done(done), .res_cls(res_cls), .res_snan(res_snan),
    .res_sign(res_sign), .res_exp(res_exp), .res_mant(res_mant),
    .res_sticky(res_sticky), .flag_nv(flag_nv), .flag_dz(flag_dz)
  );

  // {cls,snan,sign,exp,mant} dividend, then divisor; classes 0 zero 1 norm 2 inf 3 NaN
  localparam logic [51:0] VEC [NV] = '{
    {2'd1,1'b0,1'b0,10'd5,  12'hC00, 2'd1,1'b0,1'b0,10'd2,  12'h800},
    {2'd1,1'b0,1'b1,10'd3,  12'h800, 2'd1,1'b0,1'b0,10'd7,  12'hC00},
    {2'd1,1'b0,1'b1,10'd100,12'hFFF, 2'd1,1'b0,1'b1,10'd1,  12'h801},
    {2'd1,1'b0,1'b0,10'd0,  12'h800, 2'd1,1'b0,1'b1,10'd0,  12'hFFF},
    {2'd1,1'b0,1'b0,10'd9,  12'hA37, 2'd1,1'b0,1'b0,10'd9,  12'hA37},
    {2'd1,1'b0,1'b1,10'd20, 12'h801, 2'd1,1'b0,1'b1,10'd30, 12'h800},
    {2'd3,1'b1,1'b0,10'd1,  12'h911, 2'd3,1'b0,1'b1,10'd2,  12'hC22},
    {2'd3,1'b0,1'b0,10'd3,  12'hC33, 2'd3,1'b1,1'b1,10'd4,  12'h944},
    {2'd3,1'b0,1'b1,10'd5,  12'hC55, 2'd3,1'b0,1'b0,10'd6,  12'hC66},
    {2'd1,1'b0,1'b0,10'd7,  12'h877, 2'd3,1'b0,1'b1,10'd8,  12'hC88},
    {2'd3,1'b1,1'b1,10'd9,  12'h999, 2'd1,1'b0,1'b0,10'd10, 12'h8AA},
    {2'd2,1'b0,1'b1,10'd0,  12'h800, 2'd2,1'b0,1'b0,10'd0,  12'h800},
    {2'd0,1'b0,1'b0,10'd0,  12'h000, 2'd0,1'b0,1'b1,10'd0,  12'h000},
    {2'd2,1'b0,1'b1,10'd4,  12'h800, 2'd0,1'b0,1'b0,10'd0,  12'h000},
    {2'd0,1'b0,1'b1,10'd0,  12'h000, 2'd2,1'b0,1'b0,10'd0,  12'h800},
    {2'd0,1'b0,1'b1,10'd0,  12'h000, 2'd1,1'b0,1'b0,10'd3,  12'hB00},
    {2'd1,1'b0,1'b1,10'd12, 12'hA00, 2'd2,1'b0,1'b0,10'd0,  12'h800},
    {2'd1,1'b0,1'b0,10'd13, 12'h900, 2'd0,1'b0,1'b1,10'd0,  12'h000},
    {2'd2,1'b0,1'b1,10'd2,  12'h800, 2'd1,1'b0,1'b0,10'd5,  12'hC00}
  };

  // expected values
  logic [1:0] e_cls;
  logic e_snan, e_sign, e_sticky, e_nv, e_dz;
  logic [EW-1:0] e_exp;
  logic [MW-1:0] e_mant;
  int e_lat;
  string e_req;

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [51:0] v);
    {a_cls, a_snan, a_sign, a_exp, a_mant, b_cls, b_snan, b_sign, b_exp, b_mant} = v;
  endtask

  task automatic model(input logic [51:0] v);
    logic [1:0] ac, bc;
    logic as, asg, bs, bsg;
    logic [EW-1:0] ae, be;
    logic [MW-1:0] am, bm;
    longint num;
    {ac, as, asg, ae, am, bc, bs, bsg, be, bm} = v;
    e_sticky = 1'b0; e_nv = 1'b0; e_dz = 1'b0; e_lat = 1;
    {e_cls, e_snan, e_sign, e_exp, e_mant} = {ac, as, asg, ae, am};
    if (ac == 2'd3 || bc == 2'd3) begin
      e_req = "R5";
      if (!(ac == 2'd3 && (bc != 2'd3 || (as && !bs))))
        {e_cls, e_snan, e_sign, e_exp, e_mant} = {bc, bs, bsg, be, bm};
    end else if (ac == 2'd2 || ac == 2'd0) begin
      if (ac == bc) begin
        e_req = "R6";
        {e_cls, e_snan, e_sign, e_exp, e_mant} = {2'd3, 1'b0, 1'b0, {EW{1'b0}}, 12'h400};
        e_nv = 1'b1;
      end else e_req = "R7";
    end else if (bc == 2'd2) begin
      e_req = "R8"; e_cls = 2'd0; e_sign = asg ^ bsg;
    end else if (bc == 2'd0) begin
      e_req = "R8"; e_cls = 2'd2; e_sign = asg ^ bsg; e_dz = 1'b1;
    end else begin
      e_req = "R1";
      e_sign = asg ^ bsg;
      if (am >= bm) begin
        num = longint'(am) << (MW - 1); e_exp = ae - be; e_lat = MW;
      end else begin
        num = longint'(am) << MW; e_exp = ae - be - 10'd1; e_lat = MW + 1;
      end
      e_mant = MW'(num / longint'(bm));
      e_sticky = (num % longint'(bm)) != 0;
    end
  endtask

  // caller stands at a negedge; returns at the negedge where done is seen
  task automatic run(output int cycles);
    start = 1'b1;
    cycles = 0;
    do begin
      @(negedge clk);
      cycles++;
      start = 1'b0;
    end while (!done && cycles < 3 * MW);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cyc;
    logic [MW-1:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    check("R11", "busy", 64'(busy), 64'd0);
    check("R11", "done", 64'(done), 64'd0);
    check("R11", "flags", 64'({flag_nv, flag_dz}), 64'd0);
    check("R11", "result", 64'({res_cls, res_sign, res_exp, res_mant, res_sticky}), 64'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      model(VEC[i]);
      run(cyc);
      check("R9", $sformatf("latency v%0d", i), 64'(cyc), 64'(e_lat));
      check(e_req, $sformatf("class v%0d", i), 64'({res_cls, res_snan}), 64'({e_cls, e_snan}));
      check(e_req == "R1" ? "R4" : e_req, $sformatf("sign v%0d", i), 64'(res_sign), 64'(e_sign));
      check(e_req == "R1" ? "R2" : e_req, $sformatf("exp v%0d", i), 64'(res_exp), 64'(e_exp));
      check(e_req, $sformatf("mant v%0d", i), 64'(res_mant), 64'(e_mant));
      check("R3", $sformatf("sticky v%0d", i), 64'(res_sticky), 64'(e_sticky));
      check(e_req == "R1" ? "R4" : e_req, $sformatf("flags v%0d", i),
            64'({flag_nv, flag_dz}), 64'({e_nv, e_dz}));
      @(negedge clk);
      check("R9", $sformatf("done pulse v%0d", i), 64'(done), 64'd0);
    end

    // R12: result held while idle
    held = res_mant;
    repeat (5) @(negedge clk);
    check("R12", "held mant", 64'(res_mant), 64'(held));

    // R10: a start during iteration is ignored
    drive(VEC[1]);
    model(VEC[1]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R9", "busy mid-op", 64'(busy), 64'd1);
    drive(VEC[11]);
    start = 1'b1;
    cyc = 2;
    do begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
    end while (!done && cyc < 3 * MW);
    check("R10", "latency with stray start", 64'(cyc), 64'(e_lat));
    check("R10", "mant with stray start", 64'(res_mant), 64'(e_mant));
    check("R10", "nv with stray start", 64'(flag_nv), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule